// File: doc/BRIEF.md
# Multi-Port First-Error Capture Unit

This block sits next to a multi-port memory controller. It records the first bus error that any port reports and holds it until software has read it. Each port has two error sources. A command-error source supplies a faulting address, a source ID and a type mask. A data-error source supplies a source ID and a type mask, with no address.

The two kinds are captured in separate slots. Each slot has its own status bit and its own acknowledge. When a slot is empty it takes the error from the lowest-numbered port that reports one in that cycle. It then locks and ignores every later error until it is acknowledged. A single level interrupt output is high while either status bit is set.

Top module: `err_first_capture`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears both status bits, all captured fields and irq to zero.
- R2: When the command slot is unlocked and any cmd_err_vld bit is high at a clock edge, the next cycle shows cmd_stat=1, and cmd_cap_addr, cmd_cap_id and cmd_cap_type hold that port's values.
- R3: A data error sets dat_stat and captures the port's ID and type into dat_cap_id and dat_cap_type. A data error never changes cmd_stat or the command capture fields, and a command error never changes the data slot.
- R4: The type fields are bit masks and are captured bit for bit. A value with several bits set (for example 4'b1010) reads back unchanged.
- R5: While a slot is locked and not acknowledged, its status stays 1 and its captured fields do not change, whatever errors arrive. Those later errors are lost.
- R6: When several ports of one slot report an error at the same edge, the fields of the lowest-indexed port (bit 0 of the valid vector is port 0) are captured.
- R7: ack_cmd clears cmd_stat on the next cycle and leaves the data slot untouched. ack_dat clears dat_stat and leaves the command slot untouched.
- R8: An error that arrives at the same edge as its slot's acknowledge is captured, so the slot ends locked and holds the new error.
- R9: irq is 1 exactly when cmd_stat or dat_stat is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_err_vld | input | NUM_PORTS | Command-error strobe per port (bit p = port p) |
| cmd_err_addr | input | NUM_PORTS*ADDR_W | Faulting address per port (port p in slice p) |
| cmd_err_id | input | NUM_PORTS*ID_W | Command source ID per port |
| cmd_err_type | input | NUM_PORTS*TYPE_W | Command error type mask per port |
| dat_err_vld | input | NUM_PORTS | Data-error strobe per port |
| dat_err_id | input | NUM_PORTS*ID_W | Data-error source ID per port |
| dat_err_type | input | NUM_PORTS*TYPE_W | Data error type mask per port |
| ack_cmd | input | 1 | Re-arm the command slot |
| ack_dat | input | 1 | Re-arm the data slot |
| cmd_stat | output | 1 | Command slot holds an error |
| cmd_cap_addr | output | ADDR_W | Captured command address |
| cmd_cap_id | output | ID_W | Captured command source ID |
| cmd_cap_type | output | TYPE_W | Captured command type mask |
| dat_stat | output | 1 | Data slot holds an error |
| dat_cap_id | output | ID_W | Captured data-error source ID |
| dat_cap_type | output | TYPE_W | Captured data-error type mask |
| irq | output | 1 | Level interrupt, any status set |

## Verification
The bench sends errors that arrive while a slot is already locked. A design that overwrites the slot would show the later address or ID in place of the first. It also raises several ports at once with distinct payloads, in both port orders. A reversed or broken priority picker would then return the highest or a mixed port's fields. An acknowledge is made to coincide with a fresh error, which a clear-after-capture ordering would lose. Each acknowledge is also driven alone, which exposes a design that couples the two slots or lets one acknowledge clear the other.

// File: rtl/efc_pkg.sv
package efc_pkg;
    localparam int DEF_PORTS  = 4;
    localparam int DEF_ADDR_W = 32;
    localparam int DEF_ID_W   = 8;
    localparam int DEF_TYPE_W = 4;
endpackage

// File: rtl/efc_lowest_pick.sv
module efc_lowest_pick #(
    parameter int NP = 4,
    parameter int PW = 8
) (
    input  logic [NP-1:0]    vld,
    input  logic [NP*PW-1:0] pay,
    output logic             hit,
    output logic [PW-1:0]    sel
);
    always_comb begin
        sel = '0;
        for (int i = NP - 1; i >= 0; i--) begin
            if (vld[i]) sel = pay[i*PW +: PW];
        end
    end

    assign hit = |vld;
endmodule

// File: rtl/efc_capture_slot.sv
module efc_capture_slot #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  logic [PW-1:0] pay,
    input  logic          ack,
    output logic          locked,
    output logic [PW-1:0] held
);
    typedef struct packed {
        logic          lock;
        logic [PW-1:0] pay;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // re-arm first, so a coincident error still lands
        if (ack) st_d.lock = 1'b0;
        if (!st_d.lock && hit) begin
            st_d.lock = 1'b1;
            st_d.pay  = pay;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign locked = st_q.lock;
    assign held   = st_q.pay;
endmodule

// File: rtl/err_first_capture.sv
module err_first_capture #(
    parameter int NUM_PORTS = efc_pkg::DEF_PORTS,
    parameter int ADDR_W    = efc_pkg::DEF_ADDR_W,
    parameter int ID_W      = efc_pkg::DEF_ID_W,
    parameter int TYPE_W    = efc_pkg::DEF_TYPE_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS-1:0]        cmd_err_vld,
    input  logic [NUM_PORTS*ADDR_W-1:0] cmd_err_addr,
    input  logic [NUM_PORTS*ID_W-1:0]   cmd_err_id,
    input  logic [NUM_PORTS*TYPE_W-1:0] cmd_err_type,
    input  logic [NUM_PORTS-1:0]        dat_err_vld,
    input  logic [NUM_PORTS*ID_W-1:0]   dat_err_id,
    input  logic [NUM_PORTS*TYPE_W-1:0] dat_err_type,
    input  logic                        ack_cmd,
    input  logic                        ack_dat,
    output logic                        cmd_stat,
    output logic [ADDR_W-1:0]           cmd_cap_addr,
    output logic [ID_W-1:0]             cmd_cap_id,
    output logic [TYPE_W-1:0]           cmd_cap_type,
    output logic                        dat_stat,
    output logic [ID_W-1:0]             dat_cap_id,
    output logic [TYPE_W-1:0]           dat_cap_type,
    output logic                        irq
);
    localparam int CPW = ADDR_W + ID_W + TYPE_W;
    localparam int DPW = ID_W + TYPE_W;

    logic [NUM_PORTS*CPW-1:0] cmd_pay;
    logic [NUM_PORTS*DPW-1:0] dat_pay;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pack
        assign cmd_pay[p*CPW +: CPW] = {cmd_err_addr[p*ADDR_W +: ADDR_W],
                                        cmd_err_id[p*ID_W +: ID_W],
                                        cmd_err_type[p*TYPE_W +: TYPE_W]};
        assign dat_pay[p*DPW +: DPW] = {dat_err_id[p*ID_W +: ID_W],
                                        dat_err_type[p*TYPE_W +: TYPE_W]};
    end

    logic           cmd_hit, dat_hit;
    logic [CPW-1:0] cmd_sel, cmd_held;
    logic [DPW-1:0] dat_sel, dat_held;

    efc_lowest_pick #(.NP(NUM_PORTS), .PW(CPW)) u_cmd_pick (
        .vld(cmd_err_vld), .pay(cmd_pay), .hit(cmd_hit), .sel(cmd_sel)
    );

    efc_lowest_pick #(.NP(NUM_PORTS), .PW(DPW)) u_dat_pick (
        .vld(dat_err_vld), .pay(dat_pay), .hit(dat_hit), .sel(dat_sel)
    );

    efc_capture_slot #(.PW(CPW)) u_cmd_slot (
        .clk(clk), .rst(rst), .hit(cmd_hit), .pay(cmd_sel), .ack(ack_cmd),
        .locked(cmd_stat), .held(cmd_held)
    );

    efc_capture_slot #(.PW(DPW)) u_dat_slot (
        .clk(clk), .rst(rst), .hit(dat_hit), .pay(dat_sel), .ack(ack_dat),
        .locked(dat_stat), .held(dat_held)
    );

    assign {cmd_cap_addr, cmd_cap_id, cmd_cap_type} = cmd_held;
    assign {dat_cap_id, dat_cap_type}               = dat_held;
    assign irq = cmd_stat | dat_stat;
endmodule

// File: rtl/efc_checker.sv
module efc_checker #(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 32,
    parameter int ID_W      = 8,
    parameter int TYPE_W    = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_PORTS-1:0]      cmd_err_vld,
    input logic [NUM_PORTS-1:0]      dat_err_vld,
    input logic [NUM_PORTS*ID_W-1:0] dat_err_id,
    input logic                      ack_cmd,
    input logic                      ack_dat,
    input logic                      cmd_stat,
    input logic [ADDR_W-1:0]         cmd_cap_addr,
    input logic [ID_W-1:0]           cmd_cap_id,
    input logic [TYPE_W-1:0]         cmd_cap_type,
    input logic                      dat_stat,
    input logic [ID_W-1:0]           dat_cap_id,
    input logic [TYPE_W-1:0]         dat_cap_type,
    input logic                      irq
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!cmd_stat && !dat_stat && !irq));

    // R2
    cmd_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|cmd_err_vld) |=> cmd_stat);

    // R5
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_stat && !ack_cmd) |=> (cmd_stat && $stable(cmd_cap_addr)
                                    && $stable(cmd_cap_id) && $stable(cmd_cap_type)));

    // R5
    dat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_stat && !ack_dat) |=> (dat_stat && $stable(dat_cap_id)
                                    && $stable(dat_cap_type)));

    // R7
    cmd_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_cmd && !(|cmd_err_vld)) |=> !cmd_stat);

    // R7
    dat_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_dat && !(|dat_err_vld)) |=> !dat_stat);

    // R6 R8
    dat_port0_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_err_vld[0] && (!dat_stat || ack_dat)) |=>
            (dat_cap_id == $past(dat_err_id[ID_W-1:0])));

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past((|cmd_err_vld) || (|dat_err_vld)));
endmodule

bind err_first_capture efc_checker #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .ID_W(ID_W), .TYPE_W(TYPE_W)
) u_efc_checker (
    .clk(clk), .rst(rst), .cmd_err_vld(cmd_err_vld), .dat_err_vld(dat_err_vld),
    .dat_err_id(dat_err_id), .ack_cmd(ack_cmd), .ack_dat(ack_dat),
    .cmd_stat(cmd_stat), .cmd_cap_addr(cmd_cap_addr), .cmd_cap_id(cmd_cap_id),
    .cmd_cap_type(cmd_cap_type), .dat_stat(dat_stat), .dat_cap_id(dat_cap_id),
    .dat_cap_type(dat_cap_type), .irq(irq)
);

// File: tb/err_first_capture_bench.sv
module err_first_capture_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int AW = 32;
    localparam int IW = 8;
    localparam int TW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NP-1:0] c_vld, d_vld;
    logic [AW-1:0] c_addr [NP];
    logic [IW-1:0] c_id [NP];
    logic [IW-1:0] d_id [NP];
    logic [TW-1:0] c_typ [NP];
    logic [TW-1:0] d_typ [NP];
    logic          ack_c, ack_d;

    logic [NP*AW-1:0] p_caddr;
    logic [NP*IW-1:0] p_cid, p_did;
    logic [NP*TW-1:0] p_ctyp, p_dtyp;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            p_caddr[p*AW +: AW] = c_addr[p];
            p_cid[p*IW +: IW]   = c_id[p];
            p_did[p*IW +: IW]   = d_id[p];
            p_ctyp[p*TW +: TW]  = c_typ[p];
            p_dtyp[p*TW +: TW]  = d_typ[p];
        end
    end

    logic          cmd_stat, dat_stat, irq;
    logic [AW-1:0] cmd_cap_addr;
    logic [IW-1:0] cmd_cap_id, dat_cap_id;
    logic [TW-1:0] cmd_cap_type, dat_cap_type;

    err_first_capture u_err_first_capture (
        .clk(clk), .rst(rst),
        .cmd_err_vld(c_vld), .cmd_err_addr(p_caddr), .cmd_err_id(p_cid),
        .cmd_err_type(p_ctyp), .dat_err_vld(d_vld), .dat_err_id(p_did),
        .dat_err_type(p_dtyp), .ack_cmd(ack_c), .ack_dat(ack_d),
        .cmd_stat(cmd_stat), .cmd_cap_addr(cmd_cap_addr), .cmd_cap_id(cmd_cap_id),
        .cmd_cap_type(cmd_cap_type), .dat_stat(dat_stat), .dat_cap_id(dat_cap_id),
        .dat_cap_type(dat_cap_type), .irq(irq)
    );

    // behavioural reference
    logic          m_cs, m_ds;
    logic [AW-1:0] m_ca;
    logic [IW-1:0] m_ci, m_di;
    logic [TW-1:0] m_ct, m_dt;

    always @(posedge clk) begin
        if (rst) begin
            m_cs = 0; m_ca = 0; m_ci = 0; m_ct = 0;
            m_ds = 0; m_di = 0; m_dt = 0;
        end else begin
            if (ack_c) m_cs = 0;
            if (ack_d) m_ds = 0;
            for (int p = 0; p < NP; p++) begin
                if (c_vld[p] && !m_cs) begin
                    m_cs = 1; m_ca = c_addr[p]; m_ci = c_id[p]; m_ct = c_typ[p];
                end
            end
            for (int p = 0; p < NP; p++) begin
                if (d_vld[p] && !m_ds) begin
                    m_ds = 1; m_di = d_id[p]; m_dt = d_typ[p];
                end
            end
        end
    end

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic cmp_model(string req);
        chk(req, "model cmd_stat", 64'(cmd_stat), 64'(m_cs));
        chk(req, "model cmd_addr", 64'(cmd_cap_addr), 64'(m_ca));
        chk(req, "model cmd_id", 64'(cmd_cap_id), 64'(m_ci));
        chk(req, "model cmd_type", 64'(cmd_cap_type), 64'(m_ct));
        chk(req, "model dat_stat", 64'(dat_stat), 64'(m_ds));
        chk(req, "model dat_id", 64'(dat_cap_id), 64'(m_di));
        chk(req, "model dat_type", 64'(dat_cap_type), 64'(m_dt));
        chk(req, "model irq", 64'(irq), 64'(m_cs | m_ds));
    endtask

    task automatic idle();
        c_vld = '0; d_vld = '0; ack_c = 0; ack_d = 0;
        for (int p = 0; p < NP; p++) begin
            c_addr[p] = $urandom; c_id[p] = 8'($urandom); c_typ[p] = 4'($urandom);
            d_id[p] = 8'($urandom); d_typ[p] = 4'($urandom);
        end
    endtask

    task automatic cyc(string req);
        @(posedge clk);
        @(negedge clk);
        cmp_model(req);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", "cmd_stat", 64'(cmd_stat), 0);
        chk("R1", "dat_stat", 64'(dat_stat), 0);
        chk("R1", "cmd_addr", 64'(cmd_cap_addr), 0);
        chk("R1", "irq", 64'(irq), 0);

        // R2 R4 single command error on port 2, multi-bit type
        c_vld = 4'b0100; c_addr[2] = 32'hDEAD_0040; c_id[2] = 8'h5A; c_typ[2] = 4'b1010;
        cyc("R2"); idle();
        chk("R2", "cmd_stat", 64'(cmd_stat), 1);
        chk("R2", "cmd_addr", 64'(cmd_cap_addr), 64'h0000_0000_DEAD_0040);
        chk("R2", "cmd_id", 64'(cmd_cap_id), 64'h5A);
        chk("R4", "cmd_type", 64'(cmd_cap_type), 64'hA);
        chk("R3", "dat_stat untouched", 64'(dat_stat), 0);
        chk("R9", "irq", 64'(irq), 1);

        // R5 later error lost
        c_vld = 4'b0001; c_addr[0] = 32'h1111_2222; c_id[0] = 8'h01;
        cyc("R5"); idle();
        chk("R5", "cmd_addr kept", 64'(cmd_cap_addr), 64'h0000_0000_DEAD_0040);
        chk("R5", "cmd_id kept", 64'(cmd_cap_id), 64'h5A);

        // R6 R3 simultaneous data errors on ports 1 and 3
        d_vld = 4'b1010; d_id[1] = 8'h21; d_typ[1] = 4'b0110;
        d_id[3] = 8'h43; d_typ[3] = 4'b1111;
        cyc("R6"); idle();
        chk("R3", "dat_stat", 64'(dat_stat), 1);
        chk("R6", "dat_id", 64'(dat_cap_id), 64'h21);
        chk("R6", "dat_type", 64'(dat_cap_type), 64'h6);
        chk("R3", "cmd_addr untouched", 64'(cmd_cap_addr), 64'h0000_0000_DEAD_0040);

        // R7 ack_cmd alone
        ack_c = 1;
        cyc("R7"); idle();
        chk("R7", "cmd_stat cleared", 64'(cmd_stat), 0);
        chk("R7", "dat_stat kept", 64'(dat_stat), 1);
        chk("R7", "dat_id kept", 64'(dat_cap_id), 64'h21);
        chk("R9", "irq data only", 64'(irq), 1);

        // R6 command side, ports 1 and 3
        c_vld = 4'b1010; c_id[1] = 8'h31; c_addr[1] = 32'h0000_1000;
        c_id[3] = 8'h33; c_addr[3] = 32'h0000_3000;
        cyc("R6"); idle();
        chk("R6", "cmd_id", 64'(cmd_cap_id), 64'h31);
        chk("R6", "cmd_addr", 64'(cmd_cap_addr), 64'h1000);

        // R8 ack with a coincident error
        ack_c = 1; c_vld = 4'b1000; c_id[3] = 8'h77; c_addr[3] = 32'hCAFE_0000;
        cyc("R8"); idle();
        chk("R8", "cmd_stat", 64'(cmd_stat), 1);
        chk("R8", "cmd_id", 64'(cmd_cap_id), 64'h77);
        chk("R8", "cmd_addr", 64'(cmd_cap_addr), 64'hCAFE_0000);

        // R8 data side
        ack_d = 1; d_vld = 4'b0100; d_id[2] = 8'h99; d_typ[2] = 4'b0011;
        cyc("R8"); idle();
        chk("R8", "dat_id", 64'(dat_cap_id), 64'h99);
        chk("R8", "dat_type", 64'(dat_cap_type), 64'h3);

        // R9 R7 both acknowledged
        ack_c = 1; ack_d = 1;
        cyc("R7"); idle();
        chk("R9", "irq low", 64'(irq), 0);
        chk("R7", "dat_stat", 64'(dat_stat), 0);

        // random traffic against the model (R5 R6 R8)
        for (int i = 0; i < 500; i++) begin
            idle();
            for (int p = 0; p < NP; p++) begin
                c_vld[p] = ($urandom % 6) == 0;
                d_vld[p] = ($urandom % 6) == 0;
            end
            ack_c = ($urandom % 5) == 0;
            ack_d = ($urandom % 5) == 0;
            cyc("R5");
        end
        idle();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule